// File: doc/BRIEF.md
# PCI Base Address Register Decoder

This block holds the base address registers of a small PCI function's configuration header. Each slot gets a fixed configuration word at elaboration. From that word the block works out, once, whether the slot is I/O or memory and how wide its decode is. Everything else in the block uses that stored classification. The slot's writable mask is the only thing that sets its size.

Firmware reads and writes the slots as configuration dwords. A sizing write of all ones and a normal programming write take the same path. The block compares incoming requests against the decoded bases and raises a hit output for each slot that claims the request. A one-cycle strobe reports that a slot's decoded base has actually moved.

Top module: `pci_bar_decode`

## Requirements
- R1: A slot whose configuration word has bit 0 set is I/O and reads back bit 0 = 1, bit 1 = 0. Otherwise the slot is memory and reads back bit 0 = 0, with bits [2:1] = 2'b10 for 64-bit decode, 2'b01 for below-1 MB decode and 2'b00 for 32-bit decode. Bit 3 always reads 0.
- R2: A write stores the written dword ANDed with the slot's writable mask, so writing all ones reads back the writable mask with the type bits ORed in. The writable mask is the configuration word with bits [1:0] cleared for I/O and bits [3:0] cleared for memory. With the default configuration, slot 0 is a 4-byte I/O region, slot 1 a 4 KB memory region and slot 2 a 64 MB memory region.
- R3: A memory slot marked 64-bit (not the last slot) pairs with the next slot. The next slot holds address bits [63:32], stores the written value ANDed with its own full configuration word, and reads back with no type bits. Decode compares all 64 address bits.
- R4: An I/O slot whose configuration word has bits [31:16] = 0 decodes only address bits [15:0]. A below-1 MB memory slot keeps only writable bits [19:4] and hits only when address bits [63:20] are zero.
- R5: A slot hits when (address AND decode mask) equals its decoded base. The decoded base is the stored value; the type bits are never part of it. A 32-bit slot does not hit when address bits [63:32] are nonzero.
- R6: An I/O slot hits only for an I/O request with the I/O enable set. A memory slot hits only for a memory request with the memory enable set. With both enables low, no hit is reported.
- R7: base_chg bit i pulses for exactly the cycle after a write edge that changes slot i's decoded base. A write of a value that leaves the base unchanged does not pulse. A write to either half of a 64-bit pair pulses the lower slot's bit only.
- R8: Reset clears every slot to zero, so each slot reads back only its type bits, and base_chg is low.
- R9: Slot i sits at configuration dword BASE_DW + i (byte offset 0x10 upward by default). Reads of any other dword return 0, and writes to any other dword change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration dword write strobe |
| cfg_dw | input | 6 | Configuration dword index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw (combinational) |
| io_en | input | 1 | I/O space decode enable |
| mem_en | input | 1 | Memory space decode enable |
| req_io | input | 1 | Request is in I/O space (else memory) |
| req_addr | input | 64 | Request address |
| hit | output | NB | Per-slot hit |
| base_chg | output | NB | Per-slot base-changed pulse |

## Verification
The hardest case to reach is a 64-bit pair whose upper half is written after the lower half has been sized. The upper half has no type bits and must still pulse the lower slot's strobe. It must also take part in a decode that only matches when address bits above 31 agree. A second instance with a four-slot configuration sets up that pair, a below-1 MB slot and a 16-bit I/O slot. The stimulus sizes each slot and then programs it. Writing the same upper half twice shows that an unchanged base stays silent. Addresses are chosen that differ from a hit only in bits 63:32, bits 31:20 or bits 31:16.

// File: rtl/pci_bar_decode.sv
module pci_bar_decode #(
  parameter int NB = 3,
  parameter int BASE_DW = 4,
  parameter logic [NB*32-1:0] BAR_CFG = {32'hFC000000, 32'hFFFFF000, 32'hFFFFFFFF}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [5:0]      cfg_dw,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            io_en,
  input  logic            mem_en,
  input  logic            req_io,
  input  logic [63:0]     req_addr,
  output logic [NB-1:0]   hit,
  output logic [NB-1:0]   base_chg
);

  function automatic logic [31:0] f_cfg(int s);
    return BAR_CFG[s*32 +: 32];
  endfunction

  function automatic bit f_lo64(int s);
    logic [31:0] c = f_cfg(s);
    return !c[0] && c[2:1] == 2'b10 && s < NB-1;
  endfunction

  function automatic bit f_hi(int s);
    bit h = 1'b0;
    for (int k = 0; k < s; k++) h = !h && f_lo64(k);
    return h;
  endfunction

  function automatic bit f_io(int s);
    logic [31:0] c = f_cfg(s);
    return !f_hi(s) && c[0];
  endfunction

  function automatic bit f_io16(int s);
    logic [31:0] c = f_cfg(s);
    return f_io(s) && c[31:16] == 16'h0;
  endfunction

  function automatic bit f_m64(int s);
    return !f_hi(s) && f_lo64(s);
  endfunction

  function automatic bit f_m20(int s);
    logic [31:0] c = f_cfg(s);
    return !f_hi(s) && !c[0] && c[2:1] == 2'b01;
  endfunction

  function automatic logic [31:0] f_wm(int s);
    logic [31:0] c = f_cfg(s);
    if (f_hi(s))  return c;
    if (f_io(s))  return c & 32'hFFFF_FFFC;
    if (f_m20(s)) return c & 32'h000F_FFF0;
    return c & 32'hFFFF_FFF0;
  endfunction

  function automatic logic [31:0] f_tb(int s);
    if (f_hi(s))  return 32'h0;
    if (f_io(s))  return 32'h1;
    if (f_m64(s)) return 32'h4;
    if (f_m20(s)) return 32'h2;
    return 32'h0;
  endfunction

  logic [NB-1:0][31:0] bar_q, bar_d;
  logic [NB-1:0]       chg_d;

  always_comb begin
    for (int i = 0; i < NB; i++)
      bar_d[i] = (cfg_wr && cfg_dw == 6'(BASE_DW + i)) ? (cfg_wdata & f_wm(i)) : bar_q[i];
  end

  always_comb begin
    cfg_rdata = 32'h0;
    for (int i = 0; i < NB; i++)
      if (cfg_dw == 6'(BASE_DW + i)) cfg_rdata = bar_q[i] | f_tb(i);
  end

  for (genvar i = 0; i < NB; i++) begin : g_slot
    localparam bit HI = f_hi(i);
    localparam bit IO = f_io(i);
    localparam bit M64 = f_m64(i);
    localparam logic [31:0] WM = f_wm(i);
    localparam logic [31:0] CM_LO = f_m20(i) ? (WM | 32'hFFF0_0000) : WM;
    logic [63:0] base, cmask;
    logic        space_ok;

    if (HI) begin : g_hi
      assign base     = 64'h0;
      assign cmask    = 64'h0;
      assign space_ok = 1'b0;
      assign chg_d[i] = 1'b0;
    end else begin : g_main
      if (M64) begin : g_wide
        assign base     = {bar_q[i+1], bar_q[i]};
        assign cmask    = {f_wm(i+1), CM_LO};
        assign chg_d[i] = (bar_d[i] != bar_q[i]) || (bar_d[i+1] != bar_q[i+1]);
      end else begin : g_narrow
        assign base     = {32'h0, bar_q[i]};
        assign cmask    = {f_io16(i) ? 32'h0 : 32'hFFFF_FFFF, CM_LO};
        assign chg_d[i] = bar_d[i] != bar_q[i];
      end
      assign space_ok = IO ? (req_io && io_en) : (!req_io && mem_en);
    end

    assign hit[i] = space_ok && ((req_addr & cmask) == base);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q    <= '0;
      base_chg <= '0;
    end else begin
      bar_q    <= bar_d;
      base_chg <= chg_d;
    end
  end

endmodule

// File: rtl/pci_bar_decode_chk.sv
module pci_bar_decode_chk #(
  parameter int NB = 3,
  parameter int BASE_DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [5:0]    cfg_dw,
  input logic [31:0]   cfg_rdata,
  input logic          io_en,
  input logic          mem_en,
  input logic [NB-1:0] hit,
  input logic [NB-1:0] base_chg
);

  p_no_hit_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en && !mem_en) |-> hit == '0);

  p_chg_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|base_chg) |-> $past(cfg_wr));

  p_chg_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(base_chg));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_wr) && $stable(cfg_dw)) |-> $stable(cfg_rdata));

  p_outside_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_dw) < BASE_DW || 32'(cfg_dw) >= BASE_DW + NB) |-> cfg_rdata == 32'h0);

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> base_chg == '0);

endmodule

bind pci_bar_decode pci_bar_decode_chk #(.NB(NB), .BASE_DW(BASE_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_rdata(cfg_rdata),
  .io_en(io_en), .mem_en(mem_en), .hit(hit), .base_chg(base_chg)
);

// File: tb/sim_pci_bar_decode.sv
`timescale 1ns/1ps
module sim_pci_bar_decode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [5:0]  dw = '0;
  logic [31:0] wdata = '0;
  logic        io_en = 1'b0, mem_en = 1'b0, req_io = 1'b0;
  logic [63:0] req_addr = '0;
  logic [31:0] rd0, rd1;
  logic [2:0]  hit0, chg0;
  logic [3:0]  hit1, chg1;

  always #10 clk = ~clk;

  pci_bar_decode u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr0), .cfg_dw(dw), .cfg_wdata(wdata),
    .cfg_rdata(rd0), .io_en(io_en), .mem_en(mem_en), .req_io(req_io),
    .req_addr(req_addr), .hit(hit0), .base_chg(chg0)
  );

  pci_bar_decode #(
    .NB(4), .BASE_DW(4),
    .BAR_CFG({32'h0000FF01, 32'hFFFF0002, 32'hFFFFFFFF, 32'hFFF00004})
  ) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr1), .cfg_dw(dw), .cfg_wdata(wdata),
    .cfg_rdata(rd1), .io_en(io_en), .mem_en(mem_en), .req_io(req_io),
    .req_addr(req_addr), .hit(hit1), .base_chg(chg1)
  );

  typedef struct {
    bit          u;
    bit [2:0]    what;
    logic [31:0] rd;
    logic [3:0]  hit;
    logic [3:0]  chg;
    string       tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    #4;
    if (q.size() > 0) begin
      exp_t e;
      logic [31:0] ar;
      logic [3:0]  ah, ac;
      e  = q.pop_front();
      ar = e.u ? rd1 : rd0;
      ah = e.u ? hit1 : {1'b0, hit0};
      ac = e.u ? chg1 : {1'b0, chg0};
      if (e.what[0]) begin
        vectors++;
        if (ar !== e.rd) begin
          miscompares++;
          $display("FAIL %s: rdata got %h exp %h", e.tag, ar, e.rd);
        end
      end
      if (e.what[1]) begin
        vectors++;
        if (ah !== e.hit) begin
          miscompares++;
          $display("FAIL %s: hit got %b exp %b", e.tag, ah, e.hit);
        end
      end
      if (e.what[2]) begin
        vectors++;
        if (ac !== e.chg) begin
          miscompares++;
          $display("FAIL %s: base_chg got %b exp %b", e.tag, ac, e.chg);
        end
      end
    end
  end

  task automatic step(bit u, bit w, logic [5:0] d, logic [31:0] wd, bit io,
                      logic [63:0] a, bit ie, bit me, bit [2:0] what,
                      logic [31:0] er, logic [3:0] eh, logic [3:0] ec, string tag);
    exp_t e;
    @(negedge clk);
    wr0 = w && !u; wr1 = w && u;
    dw = d; wdata = wd; req_io = io; req_addr = a; io_en = ie; mem_en = me;
    if (what != 3'b000) begin
      e.u = u; e.what = what; e.rd = er; e.hit = eh; e.chg = ec; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic rd(bit u, logic [5:0] d, logic [31:0] er, string tag);
    step(u, 1'b0, d, 32'h0, 1'b0, 64'h0, 1'b0, 1'b0, 3'b101, er, 4'h0, 4'h0, tag);
  endtask

  task automatic wr(bit u, logic [5:0] d, logic [31:0] wd, logic [31:0] er,
                    logic [3:0] ec, string tag);
    step(u, 1'b1, d, wd, 1'b0, 64'h0, 1'b0, 1'b0, 3'b101, er, 4'h0, ec, tag);
  endtask

  task automatic hc(bit u, bit io, logic [63:0] a, bit ie, bit me, logic [3:0] eh, string tag);
    step(u, 1'b0, 6'd0, 32'h0, io, a, ie, me, 3'b010, 32'h0, eh, 4'h0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state, R1 type bits
    rd(0, 6'd4, 32'h00000001, "R8 R1 u0 slot0 io");
    rd(0, 6'd5, 32'h00000000, "R8 R1 u0 slot1 mem32");
    rd(0, 6'd6, 32'h00000000, "R8 u0 slot2");
    rd(1, 6'd4, 32'h00000004, "R8 R1 u1 slot0 mem64");
    rd(1, 6'd5, 32'h00000000, "R8 R3 u1 upper half");
    rd(1, 6'd6, 32'h00000002, "R8 R1 u1 slot2 below1M");
    rd(1, 6'd7, 32'h00000001, "R8 R1 u1 slot3 io16");
    hc(0, 1'b0, 64'h0, 1'b0, 1'b0, 4'h0, "R8 no hit after reset");
    // R2 sizing
    wr(0, 6'd4, 32'hFFFFFFFF, 32'hFFFFFFFD, 4'b0001, "R2 size u0 slot0");
    wr(0, 6'd5, 32'hFFFFFFFF, 32'hFFFFF000, 4'b0010, "R2 size u0 slot1");
    wr(0, 6'd6, 32'hFFFFFFFF, 32'hFC000000, 4'b0100, "R2 size u0 slot2");
    wr(1, 6'd4, 32'hFFFFFFFF, 32'hFFF00004, 4'b0001, "R2 R3 size u1 low");
    wr(1, 6'd5, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'b0001, "R3 R7 size u1 upper pulses low bit");
    wr(1, 6'd6, 32'hFFFFFFFF, 32'h000F0002, 4'b0100, "R4 size u1 below1M");
    wr(1, 6'd7, 32'hFFFFFFFF, 32'h0000FF01, 4'b1000, "R4 size u1 io16");
    // R7 unchanged rewrite
    wr(0, 6'd5, 32'hFFFFFFFF, 32'hFFFFF000, 4'b0000, "R7 same base no pulse");
    // programming
    wr(0, 6'd4, 32'h00001236, 32'h00001235, 4'b0001, "R2 program u0 slot0");
    wr(0, 6'd5, 32'h80000ABC, 32'h80000000, 4'b0010, "R2 program u0 slot1");
    wr(0, 6'd6, 32'hC3FFFFFF, 32'hC0000000, 4'b0100, "R2 program u0 slot2");
    // R9 outside offsets
    wr(0, 6'd3, 32'hDEADBEEF, 32'h00000000, 4'b0000, "R9 write below range");
    wr(0, 6'd7, 32'hDEADBEEF, 32'h00000000, 4'b0000, "R9 write above range");
    rd(0, 6'd4, 32'h00001235, "R9 slot0 untouched");
    rd(0, 6'd6, 32'hC0000000, "R9 slot2 untouched");
    // R5 R6 hits on u0
    hc(0, 1'b0, 64'h0000_0000_8000_0ABC, 1'b1, 1'b1, 4'b0010, "R5 mem hit slot1");
    hc(0, 1'b0, 64'h0000_0000_8000_1000, 1'b1, 1'b1, 4'b0000, "R5 past 4K end");
    hc(0, 1'b0, 64'h0000_0000_C123_4567, 1'b1, 1'b1, 4'b0100, "R5 mem hit slot2");
    hc(0, 1'b0, 64'h0000_0000_C400_0000, 1'b1, 1'b1, 4'b0000, "R5 past 64M end");
    hc(0, 1'b1, 64'h0000_0000_0000_1236, 1'b1, 1'b1, 4'b0001, "R5 io hit slot0");
    hc(0, 1'b0, 64'h0000_0000_0000_1234, 1'b1, 1'b1, 4'b0000, "R6 io base in mem space");
    hc(0, 1'b0, 64'h0000_0001_8000_0ABC, 1'b1, 1'b1, 4'b0000, "R5 upper bits on 32-bit slot");
    hc(0, 1'b1, 64'h0000_0000_0000_1234, 1'b0, 1'b1, 4'b0000, "R6 io disabled");
    hc(0, 1'b0, 64'h0000_0000_8000_0000, 1'b1, 1'b0, 4'b0000, "R6 mem disabled");
    // u1 64-bit pair
    wr(1, 6'd4, 32'h12300000, 32'h12300004, 4'b0001, "R3 program low half");
    wr(1, 6'd5, 32'h00000002, 32'h00000002, 4'b0001, "R3 program upper half");
    wr(1, 6'd5, 32'h00000002, 32'h00000002, 4'b0000, "R7 same upper no pulse");
    hc(1, 1'b0, 64'h0000_0002_123F_FFFF, 1'b1, 1'b1, 4'b0001, "R3 64-bit hit");
    hc(1, 1'b0, 64'h0000_0000_1230_0000, 1'b1, 1'b1, 4'b0000, "R3 upper mismatch");
    // below 1M slot
    wr(1, 6'd6, 32'h0005ABCD, 32'h00050002, 4'b0100, "R4 program below1M");
    hc(1, 1'b0, 64'h0000_0000_0005_ABCD, 1'b1, 1'b1, 4'b0100, "R4 below1M hit");
    hc(1, 1'b0, 64'h0000_0000_1005_0000, 1'b1, 1'b1, 4'b0000, "R4 below1M alias rejected");
    // io16 slot
    wr(1, 6'd7, 32'h1234AB77, 32'h0000AB01, 4'b1000, "R4 program io16");
    hc(1, 1'b1, 64'h0000_0000_0000_ABCD, 1'b1, 1'b1, 4'b1000, "R4 io16 hit");
    hc(1, 1'b1, 64'h0000_0000_0001_ABCD, 1'b1, 1'b1, 4'b1000, "R4 io16 ignores upper");
    hc(1, 1'b1, 64'h0000_0000_0000_AC00, 1'b1, 1'b1, 4'b0000, "R4 io16 miss");
    step(0, 1'b0, 6'd0, 32'h0, 1'b0, 64'h0, 1'b0, 1'b0, 3'b000, 32'h0, 4'h0, 4'h0, "idle");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule